// File: doc/BRIEF.md
# Interruption Priority and Masking Arbiter

This block sits between a processor's interruption condition detectors and its trap entry sequencer. Each of thirty pending conditions arrives on its own request line with a fixed interruption number. On each instruction boundary the arbiter applies that source's own enable rule, taken from processor status bits. It then picks the single winner by fixed priority and pulses a take strobe. The strobe comes with the winner's number and the two addresses to load into the front and back of the interrupted-instruction address queue.

Sources fall into four priority groups: the high-priority machine check alone, then asynchronous events, then instruction and data access faults and traps, then control transfer traps. A masked source does not block lower-priority sources. Its request line simply stays asserted until its enable returns. A fatal hardware error does not raise an interruption: it sets a sticky halt output that stops all further takes until reset.

Top module: `ia_arbiter`

## Requirements
- R1: After reset, take_o, halt_o, num_o, front_o and back_o are all 0.
- R2: When boundary_i is 1 and at least one request is enabled, take_o is 1 on the next clock edge for exactly that boundary. With boundary_i at 0 no take occurs.
- R3: Request bit k maps to a fixed interruption number, and a lower k has higher priority. The numbers for k = 0..29 are 1, 2, 3, 4, 5, 29, 6, 7, 30, 8, 9, 10, 11, 12, 13, 14, 15, 16, 17, 26, 27, 28, 19, 20, 21, 31, 22, 23, 24, 25. num_o gives the number of the winning bit.
- R4: Number 1 is enabled only while status bit 0 (M) is 0.
- R5: Numbers 2, 4 and 5 need status bit 1 (I) at 1. Number 29 needs status bit 2 (F) at 1. Number 3 needs status bit 3 (R) at 1, and its request line carries bit 0 of the recovery counter.
- R6: Number 30 needs status bit 4 (G) at 1 and status bit 5 (Z) at 0. Number 31 needs G at 1 and status bit 6 (Y) at 0. Number 19 is disabled while status bit 7 (X) is 1. All other group 3 numbers are always enabled.
- R7: Number 23 needs status bit 8 (H) at 1. Number 24 needs status bit 9 (L) at 1. Number 25 needs status bit 10 (T) at 1.
- R8: A masked request is skipped in favour of the next enabled one. It is taken on a later boundary once its enable returns, as long as its line is still asserted.
- R9: On a take, front_o holds cur_pc_i from the boundary cycle. back_o holds br_tgt_i when the number is 25, and nxt_pc_i otherwise.
- R10: take_o never stays high for two cycles in a row. A boundary presented while take_o is 1 is ignored.
- R11: fatal_i sets halt_o on the next clock edge, and halt_o stays set until reset. No take is produced for a boundary in the same cycle as fatal_i, or for any boundary while halt_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary, arbitration allowed this cycle |
| req_i | input | 30 | Pending conditions, bit k per the R3 list |
| status_i | input | 11 | Status bits M, I, F, R, G, Z, Y, X, H, L, T at bits 0..10 |
| cur_pc_i | input | AW | Address of the instruction at the boundary |
| nxt_pc_i | input | AW | Address of the instruction after it |
| br_tgt_i | input | AW | Target of the branch just taken |
| fatal_i | input | 1 | Unrecoverable hardware error |
| take_o | output | 1 | One-cycle take strobe |
| num_o | output | 5 | Interruption number taken |
| front_o | output | AW | Queue front address |
| back_o | output | AW | Queue back address |
| halt_o | output | 1 | Sticky halt and external check indication |

## Verification
Every result is registered once. The take strobe, number and queue addresses for a boundary driven before clock edge n are checked at the falling edge after edge n. halt_o is checked on the same falling edge after fatal_i. The bench drives each boundary for one cycle and leaves one idle cycle before the next, so R10 never suppresses a take it expects. The separate test that holds the boundary for two cycles expects the strobe only once.

// File: rtl/ia_pkg.sv
package ia_pkg;
  localparam int NSRC  = 30;
  localparam int NUM_W = 5;
  localparam int SW    = 11;
  localparam int IDX_W = $clog2(NSRC);

  localparam int ST_M = 0;
  localparam int ST_I = 1;
  localparam int ST_F = 2;
  localparam int ST_R = 3;
  localparam int ST_G = 4;
  localparam int ST_Z = 5;
  localparam int ST_Y = 6;
  localparam int ST_X = 7;
  localparam int ST_H = 8;
  localparam int ST_L = 9;
  localparam int ST_T = 10;

  localparam logic [NUM_W-1:0] NUM_BRANCH = 5'd25;

  // priority position -> interruption number
  function automatic logic [NUM_W-1:0] src_num(input int idx);
    case (idx)
      0:  return 5'd1;
      1:  return 5'd2;
      2:  return 5'd3;
      3:  return 5'd4;
      4:  return 5'd5;
      5:  return 5'd29;
      6:  return 5'd6;
      7:  return 5'd7;
      8:  return 5'd30;
      9:  return 5'd8;
      10: return 5'd9;
      11: return 5'd10;
      12: return 5'd11;
      13: return 5'd12;
      14: return 5'd13;
      15: return 5'd14;
      16: return 5'd15;
      17: return 5'd16;
      18: return 5'd17;
      19: return 5'd26;
      20: return 5'd27;
      21: return 5'd28;
      22: return 5'd19;
      23: return 5'd20;
      24: return 5'd21;
      25: return 5'd31;
      26: return 5'd22;
      27: return 5'd23;
      28: return 5'd24;
      29: return 5'd25;
      default: return '0;
    endcase
  endfunction

  function automatic logic src_en(input logic [NUM_W-1:0] num, input logic [SW-1:0] st);
    case (num)
      5'd1:              return ~st[ST_M];
      5'd2, 5'd4, 5'd5:  return st[ST_I];
      5'd29:             return st[ST_F];
      5'd3:              return st[ST_R];
      5'd30:             return st[ST_G] & ~st[ST_Z];
      5'd31:             return st[ST_G] & ~st[ST_Y];
      5'd19:             return ~st[ST_X];
      5'd23:             return st[ST_H];
      5'd24:             return st[ST_L];
      5'd25:             return st[ST_T];
      default:           return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ia_mask.sv
module ia_mask
  import ia_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [SW-1:0] status_i,
  output logic [N-1:0]  en_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    assign en_o[g] = src_en(src_num(g), status_i);
  end
endmodule

// File: rtl/ia_pick.sv
module ia_pick #(
  parameter int N  = 30,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ia_arbiter.sv
module ia_arbiter
  import ia_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic [NSRC-1:0]   req_i,
  input  logic [SW-1:0]     status_i,
  input  logic [AW-1:0]     cur_pc_i,
  input  logic [AW-1:0]     nxt_pc_i,
  input  logic [AW-1:0]     br_tgt_i,
  input  logic              fatal_i,
  output logic              take_o,
  output logic [NUM_W-1:0]  num_o,
  output logic [AW-1:0]     front_o,
  output logic [AW-1:0]     back_o,
  output logic              halt_o
);
  logic [NSRC-1:0]  en;
  logic [NSRC-1:0]  elig;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [NUM_W-1:0] win_num;
  logic             go;

  logic             take_q;
  logic             halt_q;
  logic [NUM_W-1:0] num_q;
  logic [AW-1:0]    front_q;
  logic [AW-1:0]    back_q;

  ia_mask #(.N(NSRC)) i_mask (
    .status_i (status_i),
    .en_o     (en)
  );

  assign elig = req_i & en;

  ia_pick #(.N(NSRC), .IW(IDX_W)) i_pick (
    .req_i (elig),
    .vld_o (win_vld),
    .idx_o (win_idx)
  );

  assign win_num = src_num(int'(win_idx));

  // fatal error and the cycle of a take both suppress arbitration
  assign go = boundary_i & win_vld & ~halt_q & ~take_q & ~fatal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q  <= 1'b0;
      halt_q  <= 1'b0;
      num_q   <= '0;
      front_q <= '0;
      back_q  <= '0;
    end else begin
      take_q <= go;
      halt_q <= halt_q | fatal_i;
      if (go) begin
        num_q   <= win_num;
        front_q <= cur_pc_i;
        back_q  <= (win_num == NUM_BRANCH) ? br_tgt_i : nxt_pc_i;
      end
    end
  end

  assign take_o  = take_q;
  assign halt_o  = halt_q;
  assign num_o   = num_q;
  assign front_o = front_q;
  assign back_o  = back_q;
endmodule

// File: rtl/ia_arbiter_chk.sv
module ia_arbiter_chk
  import ia_pkg::*;
#(
  parameter int AW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             boundary_i,
  input logic [SW-1:0]    status_i,
  input logic [AW-1:0]    cur_pc_i,
  input logic [AW-1:0]    br_tgt_i,
  input logic             take_o,
  input logic [NUM_W-1:0] num_o,
  input logic [AW-1:0]    front_o,
  input logic [AW-1:0]    back_o,
  input logic             halt_o
);
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  a_r2_needs_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));

  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  a_r11_halt_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !take_o);

  a_r4_hpmc_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && num_o == 5'd1) |-> !$past(status_i[ST_M]));

  a_r9_front: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> front_o == $past(cur_pc_i));

  a_r9_branch_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && num_o == NUM_BRANCH) |-> back_o == $past(br_tgt_i));
endmodule

bind ia_arbiter ia_arbiter_chk #(.AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .status_i   (status_i),
  .cur_pc_i   (cur_pc_i),
  .br_tgt_i   (br_tgt_i),
  .take_o     (take_o),
  .num_o      (num_o),
  .front_o    (front_o),
  .back_o     (back_o),
  .halt_o     (halt_o)
);

// File: tb/test_ia_arbiter.sv
module test_ia_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 30;
  localparam int SWB = 11;
  localparam int AWB = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            boundary = 1'b0;
  logic [NS-1:0]   req = '0;
  logic [SWB-1:0]  status = '0;
  logic [AWB-1:0]  cur_pc = '0;
  logic [AWB-1:0]  nxt_pc = '0;
  logic [AWB-1:0]  br_tgt = '0;
  logic            fatal = 1'b0;
  logic            take_o;
  logic [4:0]      num_o;
  logic [AWB-1:0]  front_o;
  logic [AWB-1:0]  back_o;
  logic            halt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int ord [NS] = '{1, 2, 3, 4, 5, 29, 6, 7, 30, 8, 9, 10, 11, 12, 13, 14, 15,
                   16, 17, 26, 27, 28, 19, 20, 21, 31, 22, 23, 24, 25};

  always #(CLK_PERIOD / 2) clk = ~clk;

  ia_arbiter #(.AW(AWB)) i_ia_arbiter (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .boundary_i (boundary),
    .req_i      (req),
    .status_i   (status),
    .cur_pc_i   (cur_pc),
    .nxt_pc_i   (nxt_pc),
    .br_tgt_i   (br_tgt),
    .fatal_i    (fatal),
    .take_o     (take_o),
    .num_o      (num_o),
    .front_o    (front_o),
    .back_o     (back_o),
    .halt_o     (halt_o)
  );

  // enable rules, bits M I F R G Z Y X H L T = 0..10
  function automatic bit model_en(input int n, input logic [SWB-1:0] s);
    case (n)
      1:       return !s[0];
      2, 4, 5: return s[1];
      29:      return s[2];
      3:       return s[3];
      30:      return s[4] && !s[5];
      31:      return s[4] && !s[6];
      19:      return !s[7];
      23:      return s[8];
      24:      return s[9];
      25:      return s[10];
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(input int n);
    case (n)
      1:                    return "R4";
      2, 3, 4, 5, 29:       return "R5";
      30, 31, 19:           return "R6";
      23, 24, 25:           return "R7";
      default:              return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge after one idle cycle
  task automatic do_op(input logic [NS-1:0] r, input logic [SWB-1:0] s, input string tag);
    int w;
    logic [AWB-1:0] c, n, b;
    w = -1;
    for (int i = NS - 1; i >= 0; i--) if (r[i] && model_en(ord[i], s)) w = i;
    c = $urandom; n = $urandom; b = $urandom;
    boundary = 1'b1; req = r; status = s; cur_pc = c; nxt_pc = n; br_tgt = b;
    @(negedge clk);
    boundary = 1'b0;
    chk(take_o == (w >= 0), tag, longint'(take_o), longint'(w >= 0));
    if (w >= 0) begin
      chk(num_o == ord[w], "R3", longint'(num_o), longint'(ord[w]));
      chk(front_o == c, "R9", longint'(front_o), longint'(c));
      chk(back_o == ((ord[w] == 25) ? b : n), "R9", longint'(back_o),
          longint'((ord[w] == 25) ? b : n));
    end
    @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [NS-1:0] one;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(take_o == 0, "R1", longint'(take_o), 0);
    chk(halt_o == 0, "R1", longint'(halt_o), 0);
    chk(num_o == 0, "R1", longint'(num_o), 0);
    chk(front_o == 0 && back_o == 0, "R1", longint'(front_o | back_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 no boundary, no take
    req = '1; status = 11'h7FE;
    @(negedge clk);
    chk(take_o == 0, "R2", longint'(take_o), 0);
    req = '0;
    @(negedge clk);

    // R10 boundary held two cycles: one strobe only
    boundary = 1'b1; req = NS'(1) << 3; status = 11'h002;
    @(negedge clk);
    chk(take_o == 1, "R10", longint'(take_o), 1);
    @(negedge clk);
    chk(take_o == 0, "R10", longint'(take_o), 0);
    boundary = 1'b0;
    @(negedge clk);
    chk(take_o == 0, "R10", longint'(take_o), 0);

    // R8 masked high-priority source stays pending
    one = (NS'(1) << 0) | (NS'(1) << 3);
    do_op(one, 11'h003, "R8");
    do_op(one, 11'h002, "R8");

    // R9 taken branch and a transfer trap
    do_op(NS'(1) << 29, 11'h400, "R9");
    do_op(NS'(1) << 27, 11'h100, "R9");

    // R3 all requests, every status pattern
    for (int s = 0; s < 2048; s++) do_op('1, SWB'(s), "R3");

    // per-source enable sweep
    for (int i = 0; i < NS; i++)
      for (int s = 0; s < 2048; s += 7)
        do_op(NS'(1) << i, SWB'(s), tag_of(ord[i]));

    // random mixes
    for (int k = 0; k < 2000; k++) do_op(NS'($urandom) & NS'($urandom), SWB'($urandom), "R3");

    // R11 fatal in the same cycle as a boundary
    fatal = 1'b1; boundary = 1'b1; req = '1; status = '0;
    @(negedge clk);
    fatal = 1'b0; boundary = 1'b0;
    chk(take_o == 0, "R11", longint'(take_o), 0);
    chk(halt_o == 1, "R11", longint'(halt_o), 1);
    @(negedge clk);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk(take_o == 0, "R11", longint'(take_o), 0);
    chk(halt_o == 1, "R11", longint'(halt_o), 1);
    @(negedge clk);

    // reset clears halt
    rst_ni = 1'b0;
    @(negedge clk);
    chk(halt_o == 0, "R1", longint'(halt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    do_op(NS'(1) << 6, '0, "R11");

    done = 1'b1;
    report();
  end
endmodule